// File: doc/BRIEF.md
# High-Byte Split Register Rename Stage

This block is the rename step for the integer registers of an out-of-order core in which only bits 15:8 of a register may live in a physical register of their own. It keeps 16 architectural entries. Each entry holds a full-register tag, a high-byte tag and a dirty bit. The dirty bit records that the current high byte sits in its own tag and still has to be folded into the full value. Up to four decoded micro-ops come in on each cycle. Each micro-op names a destination, an optional source, a destination width, a source width and an operation class. For every micro-op it renames, the block returns the physical source tag, the tag of the old destination value that it must also read (if any), the new destination tag, a move-eliminated flag and a flag for one extra cycle of source latency.

A read of the 16-, 32- or 64-bit view of a register whose high byte is dirty cannot proceed directly. The block emits a single merge micro-op, which combines the full tag and the high-byte tag into a fresh tag. Only the slots in front of the consumer are renamed in that cycle. The consumer and every slot after it must be presented again on the next cycle, starting at slot 0. Physical tags come from a simple in-order counter, which stands in for the free list.

Top module: `prn_rename`

Encodings: the width codes are low8=0, high8=1, 16-bit=2, 32-bit=3, 64-bit=4. The class codes are write-only=0, read-modify-write=1, move=2. Slot i occupies bits [i*4+:4] of the register fields, [i*3+:3] of the width fields, [i*2+:2] of the class field and [i*7+:7] of the tag outputs.

## Requirements
- R1: After reset, architectural register k maps to physical tag k and every high byte is clean. Fresh tags are handed out in slot order starting at 16. A merge takes the next tag at its position. After tag 127 the next tag is 16.
- R2: A destination of width low8 always allocates a new full tag and reports the current full tag as its old value. This holds for every class, including loads with no source. It leaves the dirty state of the high byte unchanged and never causes a merge.
- R3: A high8 destination with class move (register move or load) allocates a new high-byte tag, reports no old value and marks the high byte dirty.
- R4: A high8 destination with class write-only or read-modify-write reports the current high-byte value as its old value. That value is the high tag if the byte is dirty, otherwise the full tag. The micro-op also allocates a new high-byte tag and marks the byte dirty.
- R5: A 16-, 32- or 64-bit source read of a register with a dirty high byte produces exactly one merge before the consumer. The merge reports the register, its full tag, its high tag and a fresh destination tag. `take_cnt` equals the consumer's slot index. The register is clean afterwards, with the merge tag as its full tag.
- R6: A 32- or 64-bit write-only or move destination clears the dirty state with no merge and no old value. A 16-bit destination, or a 32/64-bit read-modify-write destination, whose high byte is dirty causes a merge first. Such a destination then reports the merged full tag as its old value.
- R7: A move whose source width is low8 and whose destination width is 32 or 64, with different source and destination registers, is eliminated. The eliminated move sets the flag, gives the source's full tag as its destination tag and consumes no fresh tag. If the source's high byte is dirty, the source is merged first.
- R8: A move is never eliminated when source and destination are the same register, or when the source width is 16 or high8.
- R9: A high8 source read of a clean byte returns the full tag with the extra-latency flag set. A high8 source read of a dirty byte returns the high tag with the flag clear.
- R10: Within one group, a later slot sees the mapping written by an earlier renamed slot.
- R11: Renaming stops at the first invalid slot. `take_cnt` counts the slots renamed in the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 4 | Slot valid |
| in_dst | input | 16 | Destination register per slot |
| in_src | input | 16 | Source register per slot |
| in_has_src | input | 4 | Slot has a register source |
| in_dwid | input | 12 | Destination width code per slot |
| in_swid | input | 12 | Source width code per slot |
| in_cls | input | 8 | Operation class per slot |
| take_cnt | output | 3 | Slots renamed this cycle |
| out_vld | output | 4 | Slot renamed this cycle |
| out_psrc | output | 28 | Physical source tag per slot |
| out_pold | output | 28 | Old destination value tag per slot |
| out_has_old | output | 4 | Slot also reads its old destination value |
| out_pdst | output | 28 | Physical destination tag per slot |
| out_elim | output | 4 | Move eliminated |
| out_xlat | output | 4 | Source needs one extra latency cycle |
| mrg_vld | output | 1 | Merge micro-op emitted |
| mrg_arch | output | 4 | Register being merged |
| mrg_full | output | 7 | Full-register tag input of the merge |
| mrg_high | output | 7 | High-byte tag input of the merge |
| mrg_dst | output | 7 | Tag written by the merge |

## Verification
Each scenario starts from reset, so every tag can be predicted. Groups that mix low-byte writes with a dirty high byte show that a low-byte write leaves the pending merge in place. The next wide read must still stall at the right slot, and the bench checks the merge operands. High-byte writes are tried as moves and as immediates. This tells the fresh-allocation path apart from the path that reads the old byte. High-byte reads are made from clean and from dirty registers, which separates the shifted read from the direct one. Move groups vary the register identity and the source width to pin down exactly when elimination applies. A long run of writes walks the tag counter through its wrap.

// File: rtl/prn_pkg.sv
package prn_pkg;
    localparam int NARCH = 16;
    localparam int NPHYS = 128;
    localparam int SLOTS = 4;
    localparam int AW    = $clog2(NARCH);
    localparam int TW    = $clog2(NPHYS);

    typedef enum logic [2:0] {
        WD_L8 = 3'd0,
        WD_H8 = 3'd1,
        WD_16 = 3'd2,
        WD_32 = 3'd3,
        WD_64 = 3'd4
    } wd_e;

    typedef enum logic [1:0] {
        OC_WO  = 2'd0,
        OC_RMW = 2'd1,
        OC_MOV = 2'd2
    } oc_e;

    typedef logic [TW-1:0] tag_t;
    typedef logic [AW-1:0] arch_t;

    typedef struct packed {
        tag_t full;
        tag_t high;
        logic dirty;
    } ent_t;

    function automatic tag_t tag_next(tag_t t);
        return (t == tag_t'(NPHYS - 1)) ? tag_t'(NARCH) : t + tag_t'(1);
    endfunction

    function automatic logic is_wide(wd_e w);
        return (w == WD_16) || (w == WD_32) || (w == WD_64);
    endfunction

    function automatic logic is_full(wd_e w);
        return (w == WD_32) || (w == WD_64);
    endfunction
endpackage

// File: rtl/prn_table.sv
module prn_table
    import prn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ent_t nxt [NARCH],
    input  tag_t tag_nxt,
    output ent_t cur [NARCH],
    output tag_t tag_cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NARCH; r++) begin
                cur[r] <= '{full: tag_t'(r), high: tag_t'(r), dirty: 1'b0};
            end
            tag_cur <= tag_t'(NARCH);
        end else begin
            for (int r = 0; r < NARCH; r++) begin
                cur[r] <= nxt[r];
            end
            tag_cur <= tag_nxt;
        end
    end
endmodule

// File: rtl/prn_decide.sv
module prn_decide
    import prn_pkg::*;
(
    input  logic  go,
    input  logic  vld,
    input  arch_t dst,
    input  arch_t src,
    input  logic  has_src,
    input  wd_e   dwid,
    input  wd_e   swid,
    input  oc_e   cls,
    input  ent_t  ent_s,
    input  ent_t  ent_d,
    input  tag_t  tag_in,
    output logic  ren,
    output logic  mrg,
    output arch_t mrg_arch,
    output tag_t  mrg_full,
    output tag_t  mrg_high,
    output ent_t  mrg_ent,
    output tag_t  psrc,
    output tag_t  pold,
    output logic  has_old,
    output tag_t  pdst,
    output logic  elim,
    output logic  xlat,
    output ent_t  ent_new,
    output tag_t  tag_out
);
    logic cand, src_m, dst_m;
    ent_t me;

    always_comb begin
        cand  = (cls == OC_MOV) && has_src && (swid == WD_L8) && is_full(dwid) && (src != dst);
        src_m = ((has_src && is_wide(swid)) || cand) && ent_s.dirty;
        dst_m = ((dwid == WD_16) || (is_full(dwid) && cls == OC_RMW)) && ent_d.dirty;
        mrg   = go && vld && (src_m || dst_m);
        ren   = go && vld && !(src_m || dst_m);

        me       = src_m ? ent_s : ent_d;
        mrg_arch = src_m ? src : dst;
        mrg_full = me.full;
        mrg_high = me.high;
        mrg_ent  = '{full: tag_in, high: me.high, dirty: 1'b0};

        elim = ren && cand;
        xlat = has_src && (swid == WD_H8) && !ent_s.dirty;
        if (!has_src)
            psrc = '0;
        else if (swid == WD_H8 && ent_s.dirty)
            psrc = ent_s.high;
        else
            psrc = ent_s.full;

        pdst    = elim ? ent_s.full : tag_in;
        pold    = ent_d.full;
        has_old = 1'b0;
        ent_new = ent_d;
        case (dwid)
            WD_L8: begin
                has_old      = 1'b1;
                ent_new.full = tag_in;
            end
            WD_H8: begin
                has_old       = (cls != OC_MOV);
                pold          = ent_d.dirty ? ent_d.high : ent_d.full;
                ent_new.high  = tag_in;
                ent_new.dirty = 1'b1;
            end
            WD_16: begin
                has_old       = 1'b1;
                ent_new.full  = tag_in;
                ent_new.dirty = 1'b0;
            end
            default: begin
                has_old       = (cls == OC_RMW);
                ent_new.full  = elim ? ent_s.full : tag_in;
                ent_new.dirty = 1'b0;
            end
        endcase

        tag_out = ((ren && !elim) || mrg) ? tag_next(tag_in) : tag_in;
    end
endmodule

// File: rtl/prn_rename.sv
module prn_rename
    import prn_pkg::*;
#(
    parameter int W = SLOTS,
    localparam int CW = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    in_vld,
    input  logic [W*AW-1:0] in_dst,
    input  logic [W*AW-1:0] in_src,
    input  logic [W-1:0]    in_has_src,
    input  logic [W*3-1:0]  in_dwid,
    input  logic [W*3-1:0]  in_swid,
    input  logic [W*2-1:0]  in_cls,
    output logic [CW-1:0]   take_cnt,
    output logic [W-1:0]    out_vld,
    output logic [W*TW-1:0] out_psrc,
    output logic [W*TW-1:0] out_pold,
    output logic [W-1:0]    out_has_old,
    output logic [W*TW-1:0] out_pdst,
    output logic [W-1:0]    out_elim,
    output logic [W-1:0]    out_xlat,
    output logic            mrg_vld,
    output logic [AW-1:0]   mrg_arch,
    output logic [TW-1:0]   mrg_full,
    output logic [TW-1:0]   mrg_high,
    output logic [TW-1:0]   mrg_dst
);
    ent_t  cur [NARCH];
    ent_t  nxt [NARCH];
    tag_t  tag_cur;

    logic  go   [W+1];
    tag_t  tin  [W+1];
    ent_t  es   [W];
    ent_t  ed   [W];
    ent_t  nw   [W];
    ent_t  ment [W];
    arch_t marc [W];
    tag_t  mful [W];
    tag_t  mhig [W];
    logic  ren  [W];
    logic  mrg  [W];

    assign go[0]  = 1'b1;
    assign tin[0] = tag_cur;

    prn_table u_tab (
        .clk(clk), .rst(rst), .nxt(nxt), .tag_nxt(tin[W]),
        .cur(cur), .tag_cur(tag_cur)
    );

    for (genvar i = 0; i < W; i++) begin : g_slot
        arch_t sd, ss;
        assign sd = in_dst[i*AW +: AW];
        assign ss = in_src[i*AW +: AW];

        // forward mappings written by earlier slots of this group
        always_comb begin
            es[i] = cur[ss];
            ed[i] = cur[sd];
            for (int j = 0; j < i; j++) begin
                if (ren[j] && in_dst[j*AW +: AW] == ss) es[i] = nw[j];
                if (ren[j] && in_dst[j*AW +: AW] == sd) ed[i] = nw[j];
            end
        end

        prn_decide u_dec (
            .go(go[i]), .vld(in_vld[i]), .dst(sd), .src(ss),
            .has_src(in_has_src[i]),
            .dwid(wd_e'(in_dwid[i*3 +: 3])), .swid(wd_e'(in_swid[i*3 +: 3])),
            .cls(oc_e'(in_cls[i*2 +: 2])),
            .ent_s(es[i]), .ent_d(ed[i]), .tag_in(tin[i]),
            .ren(ren[i]), .mrg(mrg[i]), .mrg_arch(marc[i]),
            .mrg_full(mful[i]), .mrg_high(mhig[i]), .mrg_ent(ment[i]),
            .psrc(out_psrc[i*TW +: TW]), .pold(out_pold[i*TW +: TW]),
            .has_old(out_has_old[i]), .pdst(out_pdst[i*TW +: TW]),
            .elim(out_elim[i]), .xlat(out_xlat[i]),
            .ent_new(nw[i]), .tag_out(tin[i+1])
        );

        assign go[i+1]    = go[i] && in_vld[i] && !mrg[i];
        assign out_vld[i] = ren[i];
    end

    always_comb begin
        for (int r = 0; r < NARCH; r++) nxt[r] = cur[r];
        take_cnt = '0;
        mrg_vld  = 1'b0;
        mrg_arch = '0;
        mrg_full = '0;
        mrg_high = '0;
        mrg_dst  = '0;
        for (int i = 0; i < W; i++) begin
            if (ren[i]) begin
                nxt[in_dst[i*AW +: AW]] = nw[i];
                take_cnt = take_cnt + CW'(1);
            end
            if (mrg[i]) begin
                nxt[marc[i]] = ment[i];
                mrg_vld  = 1'b1;
                mrg_arch = marc[i];
                mrg_full = mful[i];
                mrg_high = mhig[i];
                mrg_dst  = ment[i].full;
            end
        end
    end
endmodule

// File: rtl/prn_rename_chk.sv
module prn_rename_chk
    import prn_pkg::*;
#(
    parameter int W = SLOTS,
    localparam int CW = $clog2(W + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic [W-1:0]    in_vld,
    input logic [W*AW-1:0] in_dst,
    input logic [W*AW-1:0] in_src,
    input logic [W-1:0]    in_has_src,
    input logic [W*3-1:0]  in_dwid,
    input logic [W*3-1:0]  in_swid,
    input logic [W*2-1:0]  in_cls,
    input logic [CW-1:0]   take_cnt,
    input logic [W-1:0]    out_vld,
    input logic [W*TW-1:0] out_psrc,
    input logic [W*TW-1:0] out_pold,
    input logic [W-1:0]    out_has_old,
    input logic [W*TW-1:0] out_pdst,
    input logic [W-1:0]    out_elim,
    input logic [W-1:0]    out_xlat,
    input logic            mrg_vld,
    input logic [AW-1:0]   mrg_arch,
    input logic [TW-1:0]   mrg_full,
    input logic [TW-1:0]   mrg_high,
    input logic [TW-1:0]   mrg_dst
);
    // R5: a merge always holds back the consumer slot
    a_r5_merge_stalls: assert property (@(posedge clk) disable iff (rst)
        mrg_vld |-> (take_cnt < CW'(W)));

    // R1: merge target is always a fresh tag
    a_r1_merge_fresh: assert property (@(posedge clk) disable iff (rst)
        mrg_vld |-> (mrg_dst >= TW'(NARCH)));

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R3: high-byte move needs no old value
        a_r3_h8_mov_no_old: assert property (@(posedge clk) disable iff (rst)
            (out_vld[i] && in_dwid[i*3 +: 3] == 3'd1 && in_cls[i*2 +: 2] == 2'd2)
            |-> !out_has_old[i]);
        // R8: elimination only across distinct registers from a low byte
        a_r8_elim_guard: assert property (@(posedge clk) disable iff (rst)
            out_elim[i] |-> (in_src[i*AW +: AW] != in_dst[i*AW +: AW]
                             && in_swid[i*3 +: 3] == 3'd0));
        // R7: eliminated move reuses the source tag
        a_r7_elim_reuse: assert property (@(posedge clk) disable iff (rst)
            out_elim[i] |-> (out_pdst[i*TW +: TW] == out_psrc[i*TW +: TW]));
        // R9: extra latency only on a high-byte source
        a_r9_xlat_h8: assert property (@(posedge clk) disable iff (rst)
            out_xlat[i] |-> (in_has_src[i] && in_swid[i*3 +: 3] == 3'd1));
        // R11: renamed slots are valid slots
        a_r11_vld_only: assert property (@(posedge clk) disable iff (rst)
            out_vld[i] |-> in_vld[i]);
    end
endmodule

bind prn_rename prn_rename_chk #(.W(W)) u_chk (.*);

// File: tb/test_prn_rename.sv
`timescale 1ns/1ps
module test_prn_rename;
    localparam int W = 4;
    localparam int TW = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0]    in_vld, in_has_src;
    logic [W*4-1:0]  in_dst, in_src;
    logic [W*3-1:0]  in_dwid, in_swid;
    logic [W*2-1:0]  in_cls;
    logic [2:0]      take_cnt;
    logic [W-1:0]    out_vld, out_has_old, out_elim, out_xlat;
    logic [W*TW-1:0] out_psrc, out_pold, out_pdst;
    logic            mrg_vld;
    logic [3:0]      mrg_arch;
    logic [TW-1:0]   mrg_full, mrg_high, mrg_dst;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prn_rename i_prn_rename (.*);

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        in_vld = '0; in_has_src = '0; in_dst = '0; in_src = '0;
        in_dwid = '0; in_swid = '0; in_cls = '0;
    endtask

    task automatic put(int s, int d, int sr, bit hs, int dw, int sw, int c);
        in_vld[s] = 1'b1;
        in_dst[s*4 +: 4] = 4'(d);
        in_src[s*4 +: 4] = 4'(sr);
        in_has_src[s] = hs;
        in_dwid[s*3 +: 3] = 3'(dw);
        in_swid[s*3 +: 3] = 3'(sw);
        in_cls[s*2 +: 2] = 2'(c);
    endtask

    function automatic int psrc(int s); return int'(out_psrc[s*TW +: TW]); endfunction
    function automatic int pold(int s); return int'(out_pold[s*TW +: TW]); endfunction
    function automatic int pdst(int s); return int'(out_pdst[s*TW +: TW]); endfunction

    task automatic step();
        @(posedge clk); #1;
        clr();
    endtask

    task automatic do_reset();
        rst = 1'b1; clr();
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // R1: identity map and first tags
    task automatic t_reset();
        do_reset();
        for (int i = 0; i < 4; i++) put(i, i + 4, i, 1, 4, 4, 0);
        #1;
        chk("R1 take", int'(take_cnt), 4);
        chk("R1 merge", int'(mrg_vld), 0);
        for (int i = 0; i < 4; i++) begin
            chk("R1 psrc", psrc(i), i);
            chk("R1 pdst", pdst(i), 16 + i);
        end
        step();
    endtask

    // R2 and R10: low byte write then forwarded wide read
    task automatic t_low();
        do_reset();
        put(0, 1, 0, 0, 0, 0, 0);
        put(1, 2, 1, 1, 4, 4, 0);
        #1;
        chk("R11 take", int'(take_cnt), 2);
        chk("R2 has_old", int'(out_has_old[0]), 1);
        chk("R2 pold", pold(0), 1);
        chk("R2 pdst", pdst(0), 16);
        chk("R10 fwd psrc", psrc(1), 16);
        chk("R10 pdst", pdst(1), 17);
        step();
    endtask

    // R3, R2, R5: high move, low rmw keeps dirty, wide read merges
    task automatic t_merge();
        do_reset();
        put(0, 3, 5, 1, 1, 0, 2);
        put(1, 3, 0, 0, 0, 0, 1);
        put(2, 6, 3, 1, 3, 3, 0);
        put(3, 7, 0, 0, 4, 0, 0);
        #1;
        chk("R3 has_old", int'(out_has_old[0]), 0);
        chk("R3 pdst", pdst(0), 16);
        chk("R2 rmw pold", pold(1), 3);
        chk("R2 rmw pdst", pdst(1), 17);
        chk("R5 take", int'(take_cnt), 2);
        chk("R5 mrg_vld", int'(mrg_vld), 1);
        chk("R5 mrg_arch", int'(mrg_arch), 3);
        chk("R5 mrg_full", int'(mrg_full), 17);
        chk("R5 mrg_high", int'(mrg_high), 16);
        chk("R5 mrg_dst", int'(mrg_dst), 18);
        step();
        put(0, 6, 3, 1, 3, 3, 0);
        #1;
        chk("R5 after merge", int'(mrg_vld), 0);
        chk("R5 consumer psrc", psrc(0), 18);
        chk("R5 consumer pdst", pdst(0), 19);
        step();
    endtask

    // R4 and R9: high byte immediate and rmw, clean/dirty high reads
    task automatic t_high();
        do_reset();
        put(0, 2, 0, 0, 1, 0, 0);
        put(1, 2, 0, 0, 1, 0, 1);
        put(2, 7, 2, 1, 0, 1, 0);
        put(3, 8, 9, 1, 0, 1, 0);
        #1;
        chk("R4 imm has_old", int'(out_has_old[0]), 1);
        chk("R4 imm pold clean", pold(0), 2);
        chk("R4 rmw pold dirty", pold(1), 16);
        chk("R9 dirty psrc", psrc(2), 17);
        chk("R9 dirty xlat", int'(out_xlat[2]), 0);
        chk("R9 clean psrc", psrc(3), 9);
        chk("R9 clean xlat", int'(out_xlat[3]), 1);
        chk("R1 pdst order", pdst(3), 19);
        step();
    endtask

    // R6: full write clears dirty, 16-bit write merges
    task automatic t_clear();
        do_reset();
        put(0, 4, 0, 0, 1, 0, 2);
        put(1, 4, 0, 0, 4, 0, 0);
        put(2, 5, 4, 1, 3, 3, 0);
        #1;
        chk("R6 no merge", int'(mrg_vld), 0);
        chk("R6 wo has_old", int'(out_has_old[1]), 0);
        chk("R6 read psrc", psrc(2), 17);
        chk("R11 take3", int'(take_cnt), 3);
        step();
        put(0, 4, 0, 0, 1, 0, 2);
        put(1, 4, 0, 0, 2, 0, 0);
        #1;
        chk("R6 w16 merge", int'(mrg_vld), 1);
        chk("R6 w16 take", int'(take_cnt), 1);
        chk("R6 mrg_full", int'(mrg_full), 17);
        chk("R6 mrg_high", int'(mrg_high), 19);
        chk("R6 mrg_dst", int'(mrg_dst), 20);
        step();
        put(0, 4, 0, 0, 2, 0, 0);
        #1;
        chk("R6 w16 pold", pold(0), 20);
        chk("R6 w16 pdst", pdst(0), 21);
        step();
    endtask

    // R7: elimination, with merge of a dirty source
    task automatic t_elim();
        do_reset();
        put(0, 2, 1, 1, 3, 0, 2);
        put(1, 3, 2, 1, 4, 4, 0);
        #1;
        chk("R7 elim", int'(out_elim[0]), 1);
        chk("R7 pdst", pdst(0), 1);
        chk("R7 consumer psrc", psrc(1), 1);
        chk("R7 no tag used", pdst(1), 16);
        step();
        put(0, 1, 0, 0, 1, 0, 2);
        put(1, 4, 1, 1, 3, 0, 2);
        #1;
        chk("R7 src merge", int'(mrg_vld), 1);
        chk("R7 merge arch", int'(mrg_arch), 1);
        chk("R7 merge full", int'(mrg_full), 1);
        chk("R7 merge dst", int'(mrg_dst), 18);
        chk("R7 take", int'(take_cnt), 1);
        step();
        put(0, 4, 1, 1, 3, 0, 2);
        #1;
        chk("R7 elim after merge", int'(out_elim[0]), 1);
        chk("R7 pdst after merge", pdst(0), 18);
        step();
    endtask

    // R8: no elimination for same register, 16-bit or high source
    task automatic t_noelim();
        do_reset();
        put(0, 5, 5, 1, 3, 0, 2);
        put(1, 7, 6, 1, 3, 2, 2);
        put(2, 9, 8, 1, 3, 1, 2);
        #1;
        chk("R8 same reg", int'(out_elim[0]), 0);
        chk("R8 same pdst", pdst(0), 16);
        chk("R8 w16 src", int'(out_elim[1]), 0);
        chk("R8 w16 pdst", pdst(1), 17);
        chk("R8 high src", int'(out_elim[2]), 0);
        chk("R8 high xlat", int'(out_xlat[2]), 1);
        step();
    endtask

    // R1: tag counter wrap
    task automatic t_wrap();
        int exp;
        do_reset();
        exp = 16;
        for (int c = 0; c < 28; c++) begin
            for (int s = 0; s < 4; s++) put(s, 0, 0, 0, 4, 0, 0);
            #1;
            for (int s = 0; s < 4; s++) begin
                chk("R1 seq", pdst(s), exp);
                exp++;
            end
            step();
        end
        put(0, 0, 0, 0, 4, 0, 0);
        #1;
        chk("R1 wrap", pdst(0), 16);
        step();
    endtask

    initial begin
        clr();
        t_reset();
        t_low();
        t_merge();
        t_high();
        t_clear();
        t_elim();
        t_noelim();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule